// File: doc/BRIEF.md
# Transfer Byte Counters with Compare Interrupt

This block tracks how many bytes have crossed each of two data ports of a compression datapath. The first port carries uncompressed data and the second carries compressed codes. Each port has its own 24-bit counter that advances by one on every cycle in which that port's byte strobe is high. A 24-bit compare value is attached to the second port's counter. When that counter steps onto the compare value, a match event is raised, so firmware is told once a programmed amount of compressed data has moved.

The block also gathers four interrupt sources into a sticky status register, with a disable mask and one interrupt output. Three of the sources are event pulses produced elsewhere: end of transfer on either port and an error found while decompressing. The fourth is the compare match. Software reaches every counter, the compare value, the status and the mask over an 8-bit register bus with a 5-bit address. Each 24-bit field appears as three byte-wide registers. Reads are combinational from the address. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `xfer_count_irq`

## Requirements
- R1: The uncompressed-side counter advances by exactly one at each clock edge where `a_byte_stb` is high and no write hits its bytes, and it wraps from 0xFFFFFF to 0x000000.
- R2: The compressed-side counter behaves the same way on `b_byte_stb`, independently of the other counter.
- R3: The uncompressed-side count is read and written at 0x07 (bits 7:0), 0x08 (bits 15:8) and 0x09 (bits 23:16). The compressed-side count is at 0x0D, 0x0E and 0x0F in the same byte order. A write replaces only the addressed byte.
- R4: When a counter byte is written in the same cycle as that counter's strobe, the write is taken and that step is lost: the other bytes keep their old value.
- R5: The compare value is read/write at 0x10 (bits 7:0), 0x11 (bits 15:8) and 0x12 (bits 23:16), and resets to 0.
- R6: Status bit 3 is set at the edge where the compressed-side counter steps to a value equal to the compare value. This happens once per arrival. Reaching equality through a write to the counter or to the compare value does not set it.
- R7: The status register reads at 0x19 with bit 0 = uncompressed-side end of transfer, bit 1 = compressed-side end of transfer, bit 2 = decompression error, bit 3 = compare match, and bits 7:4 reading 0. A one-cycle event pulse sets its bit at the next edge, and the bit stays set until cleared.
- R8: Writing 0x19 clears each status bit whose written bit is 1 and leaves bits written 0 unchanged. A source event in the same cycle as its clear leaves the bit set.
- R9: The disable mask is at 0x1A with the same bit positions as the status. It resets to 0x0F (all disabled), bits 7:4 read 0 and writes to them are dropped.
- R10: `irq` is high exactly when some status bit is 1 and its disable bit is 0. Status bits are latched while disabled.
- R11: After reset both counters, the compare value and the status are 0 and `irq` is 0. Unmapped addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_byte_stb | input | 1 | One uncompressed byte crossed the first port this cycle |
| b_byte_stb | input | 1 | One compressed byte crossed the second port this cycle |
| a_done_evt | input | 1 | Uncompressed-side end-of-transfer pulse |
| b_done_evt | input | 1 | Compressed-side end-of-transfer pulse |
| dec_err_evt | input | 1 | Decompression error pulse |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two pairs of functions can fall in the same cycle. A software write to a counter byte can coincide with that counter's byte strobe. A status clear through 0x19 can coincide with the event pulse that sets the same bit. The bench drives each pair in one clock cycle on purpose. For the first pair it expects the written byte merged into the unstepped count. For the second it expects the status bit still set, while a neighbouring bit cleared in the same write has dropped.

// File: rtl/bcnt_pkg.sv
package bcnt_pkg;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NUM_SRC = 4;

  // decoded register locations
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 5'h07;
  localparam logic [ADDR_W-1:0] B_CNT_BASE = 5'h0D;
  localparam logic [ADDR_W-1:0] B_CMP_BASE = 5'h10;
  localparam logic [ADDR_W-1:0] STAT_ADDR  = 5'h19;
  localparam logic [ADDR_W-1:0] MASK_ADDR  = 5'h1A;

  // status bit positions
  typedef enum int unsigned {
    SRC_A_DONE  = 0,
    SRC_B_DONE  = 1,
    SRC_DEC_ERR = 2,
    SRC_MATCH   = 3
  } irq_src_e;
endpackage

// File: rtl/bcnt_lane_port.sv
// Byte-lane access to a multi-byte field: write merge and read select.
module bcnt_lane_port
  import bcnt_pkg::*;
#(
  parameter int unsigned       BYTES = 3,
  parameter logic [ADDR_W-1:0] BASE  = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [BYTES*DATA_W-1:0] cur,
  output logic [BYTES*DATA_W-1:0] merged,
  output logic               wr_hit,
  output logic               rd_hit,
  output logic [DATA_W-1:0]  rd_byte
);
  localparam int unsigned W = BYTES * DATA_W;

  logic [BYTES-1:0] sel;
  logic [W-1:0]     wmask;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    localparam int unsigned       LANE_I = int'(BASE) + g;
    localparam logic [ADDR_W-1:0] LANE_A = LANE_I[ADDR_W-1:0];
    assign sel[g]                    = (addr == LANE_A);
    assign wmask[g*DATA_W +: DATA_W] = {DATA_W{sel[g] & wr_en}};
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (sel[i]) rd_byte = rd_byte | cur[i*DATA_W +: DATA_W];
    end
  end

  assign merged = (cur & ~wmask) | ({BYTES{wdata}} & wmask);
  assign wr_hit = wr_en & (|sel);
  assign rd_hit = |sel;
endmodule

// File: rtl/bcnt_counter.sv
// Byte counter with software-writable byte lanes; a write beats a step.
module bcnt_counter
  import bcnt_pkg::*;
#(
  parameter int unsigned       BYTES = 3,
  parameter logic [ADDR_W-1:0] BASE  = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_req,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_en,
  input  logic [DATA_W-1:0]       wdata,
  output logic [BYTES*DATA_W-1:0] nxt_o,
  output logic                    stepped_o,
  output logic                    rd_hit,
  output logic [DATA_W-1:0]       rd_byte
);
  localparam int unsigned W = BYTES * DATA_W;

  logic [W-1:0] cnt_q, cnt_d, merged;
  logic         wr_hit, stepped, cnt_en;

  bcnt_lane_port #(.BYTES(BYTES), .BASE(BASE)) u_lanes (
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .cur     (cnt_q),
    .merged  (merged),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit),
    .rd_byte (rd_byte)
  );

  // next-state
  always_comb begin
    stepped = step_req & ~wr_hit;
    cnt_en  = wr_hit | stepped;
    cnt_d   = wr_hit ? merged : (cnt_q + W'(1));
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign nxt_o     = cnt_en ? cnt_d : cnt_q;
  assign stepped_o = stepped;

  // R1 / R2: one step per accepted strobe, modulo the width
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !wr_hit) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R4: a write in the strobe cycle lands as written, step lost
  assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (cnt_q == $past(merged)));

  // R1: count holds without strobe or write
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_req && !wr_hit) |=> $stable(cnt_q));
endmodule

// File: rtl/bcnt_match.sv
// Compare register and step-into-equality detector.
module bcnt_match
  import bcnt_pkg::*;
#(
  parameter int unsigned       BYTES = 3,
  parameter logic [ADDR_W-1:0] BASE  = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_en,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    cnt_stepped,
  input  logic [BYTES*DATA_W-1:0] cnt_nxt,
  output logic                    match_o,
  output logic                    rd_hit,
  output logic [DATA_W-1:0]       rd_byte
);
  localparam int unsigned W = BYTES * DATA_W;

  logic [W-1:0] cmp_q, cmp_d;
  logic         wr_hit;

  bcnt_lane_port #(.BYTES(BYTES), .BASE(BASE)) u_lanes (
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .cur     (cmp_q),
    .merged  (cmp_d),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit),
    .rd_byte (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (wr_hit) cmp_q <= cmp_d;
  end

  // only a counting step can arrive at the compare value
  assign match_o = cnt_stepped & (cnt_nxt == cmp_q);

  // R6: arrival is a single-cycle event while the compare value is held
  assert_match_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && !wr_hit) |=> !match_o);
endmodule

// File: rtl/bcnt_irq.sv
// Sticky status, write-one-to-clear, disable mask, interrupt output.
module bcnt_irq
  import bcnt_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         stat_wr,
  input  logic         mask_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q, stat_d, clr_vec;
  logic [N-1:0] mask_q, mask_d;
  logic         stat_en;

  // next-state
  always_comb begin
    clr_vec = stat_wr ? wbits : '0;
    stat_en = stat_wr | (|set_vec);
    stat_d  = (stat_q & ~clr_vec) | set_vec;
    mask_d  = wbits;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= mask_d;
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);

  // R7 / R8: an event always leaves its bit set, even against a clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R7: status is sticky without events or a status write
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_vec) && !stat_wr) |=> $stable(stat_q));

  // R8: written ones clear bits that had no event that cycle
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !(|set_vec)) |=> ((stat_q & $past(wbits)) == '0));
endmodule

// File: rtl/xfer_count_irq.sv
// Top: two transfer byte counters, compare match, interrupt registers.
module xfer_count_irq
  import bcnt_pkg::*;
#(
  parameter int unsigned CNT_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_byte_stb,
  input  logic              b_byte_stb,
  input  logic              a_done_evt,
  input  logic              b_done_evt,
  input  logic              dec_err_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int unsigned CW = CNT_BYTES * DATA_W;

  logic [CW-1:0]      a_nxt, b_nxt;
  logic               a_stepped, b_stepped, match;
  logic               a_rd_hit, b_rd_hit, c_rd_hit;
  logic [DATA_W-1:0]  a_rd, b_rd, c_rd;
  logic [NUM_SRC-1:0] set_vec, stat, mask;
  logic               stat_wr, mask_wr;

  bcnt_counter #(.BYTES(CNT_BYTES), .BASE(A_CNT_BASE)) u_cnt_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_req  (a_byte_stb),
    .addr      (reg_addr),
    .wr_en     (reg_wr),
    .wdata     (reg_wdata),
    .nxt_o     (a_nxt),
    .stepped_o (a_stepped),
    .rd_hit    (a_rd_hit),
    .rd_byte   (a_rd)
  );

  bcnt_counter #(.BYTES(CNT_BYTES), .BASE(B_CNT_BASE)) u_cnt_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_req  (b_byte_stb),
    .addr      (reg_addr),
    .wr_en     (reg_wr),
    .wdata     (reg_wdata),
    .nxt_o     (b_nxt),
    .stepped_o (b_stepped),
    .rd_hit    (b_rd_hit),
    .rd_byte   (b_rd)
  );

  bcnt_match #(.BYTES(CNT_BYTES), .BASE(B_CMP_BASE)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (reg_addr),
    .wr_en       (reg_wr),
    .wdata       (reg_wdata),
    .cnt_stepped (b_stepped),
    .cnt_nxt     (b_nxt),
    .match_o     (match),
    .rd_hit      (c_rd_hit),
    .rd_byte     (c_rd)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[SRC_A_DONE]  = a_done_evt;
    set_vec[SRC_B_DONE]  = b_done_evt;
    set_vec[SRC_DEC_ERR] = dec_err_evt;
    set_vec[SRC_MATCH]   = match;
    stat_wr              = reg_wr & (reg_addr == STAT_ADDR);
    mask_wr              = reg_wr & (reg_addr == MASK_ADDR);
  end

  bcnt_irq #(.N(NUM_SRC)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .stat_wr (stat_wr),
    .mask_wr (mask_wr),
    .wbits   (reg_wdata[NUM_SRC-1:0]),
    .stat_o  (stat),
    .mask_o  (mask),
    .irq_o   (irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (a_rd_hit)                    reg_rdata = a_rd;
    else if (b_rd_hit)               reg_rdata = b_rd;
    else if (c_rd_hit)               reg_rdata = c_rd;
    else if (reg_addr == STAT_ADDR)  reg_rdata = {{(DATA_W-NUM_SRC){1'b0}}, stat};
    else if (reg_addr == MASK_ADDR)  reg_rdata = {{(DATA_W-NUM_SRC){1'b0}}, mask};
  end

  // R2: the compressed-side counter is unaffected by the other strobe
  assert_b_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_stepped && !(reg_wr && b_rd_hit)) |=> $stable(b_nxt) || b_stepped || (reg_wr && b_rd_hit));

  // R10: interrupt follows an enabled status bit at every sample
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0) && (mask != '1));

  // R6: a match implies the compressed side took a step
  assert_match_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> b_stepped);

  // R1: the counters step independently of event pulses
  assert_a_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    a_stepped |-> a_byte_stb);
endmodule

// File: tb/test_xfer_count_irq.sv
module test_xfer_count_irq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       a_byte_stb, b_byte_stb, a_done_evt, b_done_evt, dec_err_evt;
  logic [4:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  xfer_count_irq i_xfer_count_irq (
    .clk(clk), .rst_n(rst_n),
    .a_byte_stb(a_byte_stb), .b_byte_stb(b_byte_stb),
    .a_done_evt(a_done_evt), .b_done_evt(b_done_evt), .dec_err_evt(dec_err_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd24(input logic [4:0] base, output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    rd(base, b0); rd(base + 5'd1, b1); rd(base + 5'd2, b2);
    v = {b2, b1, b0};
  endtask

  task automatic wr24(input logic [4:0] base, input logic [23:0] v);
    wr(base, v[7:0]); wr(base + 5'd1, v[15:8]); wr(base + 5'd2, v[23:16]);
  endtask

  task automatic pulse_a(input int n);
    @(negedge clk); a_byte_stb = 1'b1;
    repeat (n) @(negedge clk);
    a_byte_stb = 1'b0;
  endtask

  task automatic pulse_b(input int n);
    @(negedge clk); b_byte_stb = 1'b1;
    repeat (n) @(negedge clk);
    b_byte_stb = 1'b0;
  endtask

  task automatic t_reset;
    logic [23:0] v; logic [7:0] d;
    rd24(5'h07, v); chk("R11 reset A count", v, 0);
    rd24(5'h0D, v); chk("R11 reset B count", v, 0);
    rd24(5'h10, v); chk("R11 reset compare", v, 0);
    rd(5'h19, d);   chk("R11 reset status", d, 0);
    rd(5'h1A, d);   chk("R9 reset mask", d, 8'h0F);
    chk("R11 reset irq", irq, 0);
  endtask

  task automatic t_count;
    logic [23:0] v;
    pulse_a(5);
    rd24(5'h07, v); chk("R1 A count after 5", v, 5);
    pulse_b(3);
    rd24(5'h0D, v); chk("R2 B count after 3", v, 3);
    rd24(5'h07, v); chk("R2 A untouched by B strobes", v, 5);
  endtask

  task automatic t_bytes;
    logic [23:0] v; logic [7:0] d;
    wr(5'h08, 8'hAB);
    rd24(5'h07, v); chk("R3 middle byte write", v, 24'h00AB05);
    rd(5'h09, d);   chk("R3 top byte untouched", d, 0);
    wr24(5'h07, 24'hFFFFFF);
    pulse_a(1);
    rd24(5'h07, v); chk("R1 wrap to zero", v, 0);
  endtask

  task automatic t_collide_cnt;
    logic [23:0] v;
    wr24(5'h0D, 24'h000010);
    @(negedge clk);
    b_byte_stb = 1'b1; reg_addr = 5'h0E; reg_wdata = 8'h22; reg_wr = 1'b1;
    @(negedge clk);
    b_byte_stb = 1'b0; reg_wr = 1'b0;
    rd24(5'h0D, v); chk("R4 write beats strobe", v, 24'h002210);
  endtask

  task automatic t_compare;
    logic [23:0] v; logic [7:0] d;
    wr24(5'h0D, 24'h0);
    wr(5'h19, 8'hFF);
    wr24(5'h10, 24'h000004);
    rd24(5'h10, v); chk("R5 compare readback", v, 4);
    pulse_b(3);
    rd(5'h19, d); chk("R6 no match below compare", d[3], 0);
    pulse_b(1);
    rd(5'h19, d); chk("R6 match on arrival", d, 8'h08);
    wr(5'h19, 8'h08);
    pulse_b(2);
    rd(5'h19, d); chk("R6 fires once", d, 0);
    wr(5'h0D, 8'h04);
    rd24(5'h0D, v); chk("R3 B low byte write", v, 4);
    rd(5'h19, d); chk("R6 write to counter no match", d, 0);
    wr(5'h10, 8'h04);
    rd(5'h19, d); chk("R6 write to compare no match", d, 0);
  endtask

  task automatic t_events;
    logic [7:0] d;
    @(negedge clk); a_done_evt = 1'b1;
    @(negedge clk); a_done_evt = 1'b0;
    rd(5'h19, d); chk("R7 A done sets bit 0", d, 8'h01);
    @(negedge clk); dec_err_evt = 1'b1;
    @(negedge clk); dec_err_evt = 1'b0;
    rd(5'h19, d); chk("R7 error sets bit 2, sticky", d, 8'h05);
    chk("R10 latched but disabled, irq low", irq, 0);
    wr(5'h1A, 8'h0B);
    chk("R10 enabled bit drives irq", irq, 1);
    rd(5'h1A, d); chk("R9 mask readback", d, 8'h0B);
    wr(5'h1A, 8'hFF);
    rd(5'h1A, d); chk("R9 upper mask bits dropped", d, 8'h0F);
    chk("R10 all disabled irq low", irq, 0);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    wr(5'h19, 8'h04);
    rd(5'h19, d); chk("R8 write one clears", d, 8'h01);
    wr(5'h19, 8'h00);
    rd(5'h19, d); chk("R8 write zero keeps", d, 8'h01);
    @(negedge clk);
    b_done_evt = 1'b1; reg_addr = 5'h19; reg_wdata = 8'h03; reg_wr = 1'b1;
    @(negedge clk);
    b_done_evt = 1'b0; reg_wr = 1'b0;
    rd(5'h19, d); chk("R8 set beats clear", d, 8'h02);
    wr(5'h1A, 8'h00);
    chk("R10 irq with enabled status", irq, 1);
    wr(5'h19, 8'h0F);
    chk("R10 irq drops after clear", irq, 0);
  endtask

  task automatic t_unmapped;
    logic [23:0] v; logic [7:0] d;
    wr(5'h1F, 8'h5A);
    wr(5'h05, 8'h5A);
    rd(5'h1F, d); chk("R11 unmapped 0x1F reads 0", d, 0);
    rd(5'h05, d); chk("R11 unmapped 0x05 reads 0", d, 0);
    rd24(5'h07, v); chk("R11 A count unchanged", v, 0);
    rd24(5'h0D, v); chk("R11 B count unchanged", v, 4);
    rd24(5'h10, v); chk("R11 compare unchanged", v, 4);
    rd(5'h1A, d); chk("R11 mask unchanged", d, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    a_byte_stb = 0; b_byte_stb = 0; a_done_evt = 0; b_done_evt = 0; dec_err_evt = 0;
    reg_addr = '0; reg_wr = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_bytes();
    t_collide_cnt();
    t_compare();
    t_events();
    t_clear();
    t_unmapped();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule